// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This controller sits between a simple request interface and a byte-wide, software-protected parallel EEPROM. A write request names a start address, a byte count and a polling mode. The controller checks that the range is legal. It then issues the three unlock writes and loads the page bytes, taking each byte from a data source indexed by the controller. Every strobe is timed in clock cycles. After the last load, the controller polls the device until the internal programming cycle has ended, or reports a timeout if it has not.

A read request performs a single timed read cycle and returns the byte. All analogue limits of the device (strobe widths, hold times, access time, the byte-load deadline and the maximum programming time) appear as cycle-count parameters, each rounded up from the clock period. The defaults assume a 4 ns clock.

Top module: `eeprom_page_writer`

## Requirements
- R1: A write request emits exactly count+3 write strobes, in this order: data 0xAA at address 0x5555, data 0x55 at 0x2AAA, data 0xA0 at 0x5555, then page byte i at start address + i for i = 0..count-1. Page byte i is the value on `src_data` while `src_idx` equals i.
- R2: Each strobe holds `mem_we_n` low for exactly T_WP cycles. Address and data stay stable while it is low. `mem_we_n` then stays high, with address and data unchanged, for at least T_WPH cycles.
- R3: While `mem_we_n` is low, `mem_oe_n` is high, `mem_dq_oe` is 1 and `mem_ce_n` is low. `mem_ce_n` stays low for the whole of an accepted operation.
- R4: In bit-7 mode (`req_toggle`=0), the controller reads the last written address repeatedly, with `mem_oe_n` low for T_RD cycles per read. It asserts `done` once bit 7 of a read equals bit 7 of the last data byte loaded.
- R5: In toggle mode (`req_toggle`=1), the controller polls the same way and asserts `done` once bit 6 of two consecutive reads is equal.
- R6: If polling has not completed after POLL_LIMIT cycles, `err_timeout` pulses for one cycle and `done` is not asserted. At most one of `done`, `err_req` and `err_timeout` is high in any cycle.
- R7: A write request with a count of 0, a count above 64, or a range that crosses a 64-byte page boundary (address bits [5:0] + count > 64) gets a one-cycle `err_req` pulse. `mem_ce_n` stays high throughout. A range that ends exactly on the boundary is accepted.
- R8: A read request (`req_write`=0) performs one read cycle at `req_addr`. `rd_data` holds the byte in the cycle where `done` is high.
- R9: During and after reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` is 0, and `req_ready` is 1 while idle.
- R10: Within a write, consecutive rising edges of `mem_we_n` are fewer than T_BLC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = page write, 0 = single read |
| req_toggle | input | 1 | Completion mode: 0 = bit-7 compare, 1 = bit-6 toggle |
| req_addr | input | 15 | Start address (write) or read address |
| req_count | input | 7 | Byte count for a write |
| req_ready | output | 1 | Controller idle |
| src_idx | output | 6 | Index of the page byte requested from the source |
| src_data | input | 8 | Page byte at `src_idx` |
| done | output | 1 | Operation completed (one-cycle pulse) |
| err_req | output | 1 | Request rejected (one-cycle pulse) |
| err_timeout | output | 1 | Polling limit exceeded (one-cycle pulse) |
| rd_data | output | 8 | Read result |
| mem_addr | output | 15 | Device address |
| mem_dq_out | output | 8 | Data driven toward the device |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Data returned by the device |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest situation to reach is the hand-over at the end of the device's internal programming cycle. Polling must keep failing while the device is busy and succeed on the first read after it finishes. The toggle mode must not stop early on a coincidental match. The bench places a behavioural device model on the bus. The model starts a programming cycle of random length on the first read after a page load. While busy it returns the complemented bit 7 and a bit 6 that flips on every read. The bench then checks that `done` appears only after the model has gone idle. A model cycle longer than POLL_LIMIT drives the timeout path.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int PAGE_BYTES = 64,
  parameter int T_WP       = 50,
  parameter int T_WPH      = 25,
  parameter int T_RD       = 50,
  parameter int POLL_LIMIT = 3_000_000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = PW + 1,
  localparam int SW = CW + 1,
  localparam int TW = $clog2(T_WP + T_WPH + T_RD + 1),
  localparam int LW = $clog2(POLL_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_toggle,
  input  logic [14:0]   req_addr,
  input  logic [CW-1:0] req_count,
  output logic          req_ready,
  output logic [PW-1:0] src_idx,
  input  logic [7:0]    src_data,
  output logic          done,
  output logic          err_req,
  output logic          err_timeout,
  output logic [7:0]    rd_data,
  output logic [14:0]   mem_addr,
  output logic [7:0]    mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [7:0]    mem_dq_in,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [SW-1:0] step;
  logic [CW-1:0] cnt;
  logic [14:0]   base, a_q;
  logic [7:0]    d_q;
  logic          rd_op, tog, prev6, have_prev;
  logic [LW-1:0] poll_n;

  wire [SW-1:0] span      = {2'b00, req_addr[PW-1:0]} + {1'b0, req_count};
  wire          bad       = (req_count == '0) || (span > SW'(PAGE_BYTES));
  wire [SW-1:0] last_step = {1'b0, cnt} + SW'(2);
  wire [SW-1:0] nstep     = step + SW'(1);
  wire          polling   = !rd_op && (st == S_RLO || st == S_RHI);
  wire          to_hit    = polling && (poll_n == LW'(POLL_LIMIT - 1));
  wire          ok_poll   = tog ? (have_prev && (mem_dq_in[6] == prev6))
                                : (mem_dq_in[7] == d_q[7]);

  assign src_idx    = PW'(step - SW'(2));
  assign req_ready  = (st == S_IDLE);
  assign mem_ce_n   = (st == S_IDLE);
  assign mem_we_n   = (st != S_WLO);
  assign mem_oe_n   = (st != S_RLO);
  assign mem_dq_oe  = (st == S_WLO) || (st == S_WHI);
  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      step <= '0;
      cnt <= '0;
      base <= '0;
      a_q <= '0;
      d_q <= '0;
      rd_op <= 1'b0;
      tog <= 1'b0;
      prev6 <= 1'b0;
      have_prev <= 1'b0;
      poll_n <= '0;
      done <= 1'b0;
      err_req <= 1'b0;
      err_timeout <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      err_req <= 1'b0;
      err_timeout <= 1'b0;
      if (polling) poll_n <= poll_n + LW'(1);
      if (to_hit) begin
        err_timeout <= 1'b1;
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            if (!req_write) begin
              rd_op <= 1'b1;
              a_q <= req_addr;
              st <= S_RLO;
              tmr <= TW'(T_RD - 1);
            end else if (bad) begin
              err_req <= 1'b1;
            end else begin
              rd_op <= 1'b0;
              tog <= req_toggle;
              base <= req_addr;
              cnt <= req_count;
              step <= '0;
              a_q <= 15'h5555;
              d_q <= 8'hAA;
              st <= S_WLO;
              tmr <= TW'(T_WP - 1);
            end
          end
          S_WLO: begin
            if (tmr == '0) begin
              st <= S_WHI;
              tmr <= TW'(T_WPH - 1);
            end else tmr <= tmr - TW'(1);
          end
          S_WHI: begin
            if (tmr != '0) tmr <= tmr - TW'(1);
            else if (step == last_step) begin
              st <= S_RLO;
              tmr <= TW'(T_RD - 1);
              poll_n <= '0;
              have_prev <= 1'b0;
            end else begin
              step <= nstep;
              st <= S_WLO;
              tmr <= TW'(T_WP - 1);
              if (nstep == SW'(1)) begin
                a_q <= 15'h2AAA;
                d_q <= 8'h55;
              end else if (nstep == SW'(2)) begin
                a_q <= 15'h5555;
                d_q <= 8'hA0;
              end else begin
                a_q <= base + 15'(src_idx);
                d_q <= src_data;
              end
            end
          end
          S_RLO: begin
            if (tmr != '0) tmr <= tmr - TW'(1);
            else if (rd_op) begin
              rd_data <= mem_dq_in;
              rd_op <= 1'b0;
              done <= 1'b1;
              st <= S_IDLE;
            end else if (ok_poll) begin
              done <= 1'b1;
              st <= S_IDLE;
            end else begin
              prev6 <= mem_dq_in[6];
              have_prev <= 1'b1;
              st <= S_RHI;
              tmr <= TW'(T_WPH - 1);
            end
          end
          S_RHI: begin
            if (tmr != '0) tmr <= tmr - TW'(1);
            else begin
              st <= S_RLO;
              tmr <= TW'(T_RD - 1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int T_WP  = 50,
  parameter int T_BLC = 37500,
  localparam int LO_W = $clog2(T_WP + 2),
  localparam int GP_W = $clog2(T_BLC + 2)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we_n,
  input logic        mem_oe_n,
  input logic        mem_ce_n,
  input logic        mem_dq_oe,
  input logic [14:0] mem_addr,
  input logic [7:0]  mem_dq_out,
  input logic        done,
  input logic        err_req,
  input logic        err_timeout,
  input logic        req_ready
);

  logic [LO_W-1:0] lo_cnt;
  logic [GP_W-1:0] gap;
  logic            we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      gap <= '0;
      we_q <= 1'b1;
    end else begin
      we_q <= mem_we_n;
      lo_cnt <= mem_we_n ? '0 : lo_cnt + LO_W'(1);
      if (mem_ce_n || (mem_we_n && !we_q)) gap <= '0;
      else if (gap < GP_W'(T_BLC)) gap <= gap + GP_W'(1);
    end
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> lo_cnt == LO_W'(T_WP)); // R2
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R2
  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n)); // R3
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_req, err_timeout})); // R6
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> (mem_ce_n && $past(mem_ce_n))); // R7
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R9
  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $rose(mem_we_n)) |-> gap < GP_W'(T_BLC)); // R10

endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.T_WP(T_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_ce_n(mem_ce_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
  .mem_dq_out(mem_dq_out), .done(done), .err_req(err_req),
  .err_timeout(err_timeout), .req_ready(req_ready)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;
  localparam int T_WP = 3, T_WPH = 2, T_RD = 3, POLL_LIMIT = 400, BLC_CYC = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_toggle = 0;
  logic [14:0] req_addr = 0;
  logic [6:0] req_count = 0;
  logic req_ready, done, err_req, err_timeout, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [5:0] src_idx;
  logic [7:0] src_data, rd_data, mem_dq_out, mem_dq_in;
  logic [14:0] mem_addr;

  always #2 clk = ~clk;

  eeprom_page_writer #(.T_WP(T_WP), .T_WPH(T_WPH), .T_RD(T_RD), .POLL_LIMIT(POLL_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_toggle(req_toggle), .req_addr(req_addr), .req_count(req_count),
    .req_ready(req_ready), .src_idx(src_idx), .src_data(src_data), .done(done),
    .err_req(err_req), .err_timeout(err_timeout), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  logic [7:0] pagebuf [64];
  assign src_data = pagebuf[src_idx];

  // device model
  logic [7:0] mem [32768];
  logic [14:0] ev_a [80];
  logic [7:0] ev_d [80];
  int ev_n = 0, busy_left = 0, busy_len = 30, lo_w = 0, hi_w = 100, gap_w = 0;
  int viol_w = 0, viol_oe = 0, viol_gap = 0;
  logic busy = 0, progd = 0, tog6 = 0, we_q = 1, oe_q = 1, ce_q = 1;
  logic [7:0] last_d = 0;

  assign mem_dq_in = busy ? {~last_d[7], tog6, last_d[5:0]} : mem[mem_addr];

  always @(posedge clk) begin
    we_q <= mem_we_n; oe_q <= mem_oe_n; ce_q <= mem_ce_n;
    lo_w <= mem_we_n ? 0 : lo_w + 1;
    hi_w <= mem_ce_n ? 100 : (mem_we_n ? hi_w + 1 : 0);
    gap_w <= gap_w + 1;
    if (!mem_we_n && !mem_oe_n) viol_oe <= viol_oe + 1;
    if (!mem_we_n && (!mem_dq_oe || mem_ce_n)) viol_oe <= viol_oe + 1;
    if (ce_q && !mem_ce_n && !busy) begin ev_n <= 0; progd <= 0; end
    if (we_q && !mem_we_n && hi_w < T_WPH) viol_w <= viol_w + 1;
    if (!we_q && mem_we_n && !mem_ce_n) begin
      if (lo_w != T_WP) viol_w <= viol_w + 1;
      if (ev_n > 0 && gap_w >= BLC_CYC) viol_gap <= viol_gap + 1;
      gap_w <= 0;
      if (!busy && ev_n < 80) begin
        ev_a[ev_n] <= mem_addr; ev_d[ev_n] <= mem_dq_out;
        ev_n <= ev_n + 1; last_d <= mem_dq_out;
      end
    end
    if (oe_q && !mem_oe_n) begin
      if (!busy && ev_n > 0 && !progd) begin
        busy <= 1; progd <= 1; busy_left <= busy_len; tog6 <= ~tog6;
      end else if (busy) tog6 <= ~tog6;
    end
    if (busy) begin
      if (busy_left == 0) begin
        busy <= 0;
        if (ev_n >= 3 && ev_a[0] == 15'h5555 && ev_d[0] == 8'hAA && ev_a[1] == 15'h2AAA &&
            ev_d[1] == 8'h55 && ev_a[2] == 15'h5555 && ev_d[2] == 8'hA0)
          for (int i = 3; i < ev_n; i++) mem[ev_a[i]] <= ev_d[i];
      end else busy_left <= busy_left - 1;
    end
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_a(int k, logic [14:0] b);
    if (k == 0 || k == 2) return 15'h5555;
    if (k == 1) return 15'h2AAA;
    return b + 15'(k - 3);
  endfunction

  function automatic logic [7:0] exp_d(int k);
    if (k == 0) return 8'hAA;
    if (k == 1) return 8'h55;
    if (k == 2) return 8'hA0;
    return pagebuf[k - 3];
  endfunction

  int res, cyc;
  bit bus, busy_at_end;

  task automatic run_req(input bit wr, input bit tg, input logic [14:0] a, input logic [6:0] n);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_toggle = tg; req_addr = a; req_count = n;
    @(negedge clk);
    req_valid = 0;
    res = 0; cyc = 0; bus = 0;
    while (res == 0 && cyc < 5000) begin
      if (!mem_ce_n) bus = 1;
      if (done) res = 1;
      else if (err_req) res = 2;
      else if (err_timeout) res = 3;
      if (res == 0) begin @(negedge clk); cyc++; end
    end
    busy_at_end = busy;
  endtask

  task automatic do_write(input logic [14:0] a, input int n, input bit tg, input int blen);
    int w0, o0, g0;
    w0 = viol_w; o0 = viol_oe; g0 = viol_gap;
    for (int i = 0; i < 64; i++) pagebuf[i] = 8'($urandom);
    busy_len = blen;
    run_req(1, tg, a, 7'(n));
    chk(res == 1, tg ? "R5 toggle-mode done" : "R4 bit7-mode done", res, 1);
    chk(!busy_at_end, tg ? "R5 done after device idle" : "R4 done after device idle", busy_at_end, 0);
    chk(ev_n == n + 3, "R1 strobe count", ev_n, n + 3);
    for (int k = 0; k < n + 3 && k < ev_n; k++) begin
      chk(ev_a[k] == exp_a(k, a), "R1 strobe address", ev_a[k], exp_a(k, a));
      chk(ev_d[k] == exp_d(k), "R1 strobe data", ev_d[k], exp_d(k));
    end
    chk(viol_w == w0, "R2 strobe timing", viol_w - w0, 0);
    chk(viol_oe == o0, "R3 enables during write", viol_oe - o0, 0);
    chk(viol_gap == g0, "R10 byte-load gap", viol_gap - g0, 0);
    for (int i = 0; i < n; i++) begin
      run_req(0, 0, a + 15'(i), 7'd1);
      chk(res == 1 && rd_data == pagebuf[i], "R8 read-back", rd_data, pagebuf[i]);
    end
  endtask

  task automatic reject(input logic [14:0] a, input logic [6:0] n);
    run_req(1, 0, a, n);
    chk(res == 2, "R7 rejected", res, 2);
    chk(!bus, "R7 no bus activity", bus, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R9 bus idle in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R9 idle after reset",
        {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);

    do_write(15'h007C, 4, 0, 25);   // ends exactly on boundary
    do_write(15'h1200, 64, 1, 40);  // full page, toggle mode
    do_write(15'h3FBF, 1, 0, 5);    // single byte, last offset
    do_write(15'h0555, 2, 1, 0);    // device finishes immediately
    for (int r = 0; r < 6; r++) begin
      int off, n;
      off = int'($urandom % 64);
      n = 1 + int'($urandom % (64 - off));
      do_write({9'($urandom), 6'(off)}, n, 1'($urandom), 10 + int'($urandom % 80));
    end

    reject(15'h0100, 7'd0);
    reject(15'h0100, 7'd65);
    reject(15'h013E, 7'd3);
    reject(15'h0101, 7'd64);

    busy_len = 1000;
    for (int i = 0; i < 64; i++) pagebuf[i] = 8'(i);
    run_req(1, 0, 15'h2000, 7'd2);
    chk(res == 3, "R6 timeout reported", res, 3);
    chk(cyc >= POLL_LIMIT, "R6 timeout not early", cyc, POLL_LIMIT);
    repeat (1100) @(negedge clk);
    run_req(0, 0, 15'h2001, 7'd1);
    chk(res == 1 && rd_data == 8'h01, "R8 read after timeout", rd_data, 8'h01);

    summary();
  end
endmodule